// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Send/Busy Handshake

This block turns one parallel character into a framed asynchronous serial stream on a single output line. A frame opens with a low start bit and carries five, seven or eight data bits, least significant first. An optional even or odd parity bit can follow the data. The frame closes with one or two high stop bits. Every bit holds the line for a fixed number of system clock cycles, derived at elaboration from the clock frequency and the target baud rate.

The host requests a transfer with a four-phase handshake. It raises `send` and keeps it high. The block answers by raising `busy` and loads the character and its framing options on the same edge. When the final stop bit has been sent, `busy` falls and the host may then lower `send`. A new frame is started only after `send` has been seen low, so a host that holds `send` high never gets a second frame by accident. The framing inputs can change freely while a frame is in flight.

Top module: `async_tx_hs`

## Requirements
- R1: After reset, `txLine` is high and `busy` is low.
- R2: While no frame is in flight the line is high. A frame starts with a low start bit on the cycle after `send` is accepted, and every bit of the frame lasts exactly CLK_HZ/BAUD clock cycles.
- R3: `dataLen` selects the data bit count: 2'b00 gives 5 bits, 2'b01 gives 7 bits, 2'b10 and 2'b11 give 8 bits. Data bits go out least significant first, starting at `dataIn[0]`; unused high bits of `dataIn` are not sent.
- R4: When `parityEn` is 1, one parity bit follows the last data bit. `parityOdd` = 0 makes the count of ones over the sent data bits plus parity even, and `parityOdd` = 1 makes it odd. Only the configured data bits count.
- R5: `stopTwo` = 0 ends the frame with one high stop bit and `stopTwo` = 1 ends it with two.
- R6: `busy` rises on the cycle after `send` is accepted in idle. It stays high for the whole frame and falls right after the last stop bit period.
- R7: If `send` is still high when a frame ends, no new frame starts and the line stays high with `busy` low until `send` has been seen low.
- R8: The data and framing inputs are captured when `send` is accepted. Changing them during a frame has no effect on that frame.
- R9: If `send` is low on the clock edge that ends a frame, the block is idle at once and a `send` raised on the next cycle starts a new frame with no extra gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 8 | Character to send |
| dataLen | input | 2 | Data bit count select (00: 5, 01: 7, 1x: 8) |
| parityEn | input | 1 | Append a parity bit when 1 |
| parityOdd | input | 1 | Parity type: 0 even, 1 odd |
| stopTwo | input | 1 | Stop bit count: 0 one, 1 two |
| send | input | 1 | Transfer request, held high by the host |
| txLine | output | 1 | Serial output line, high when idle |
| busy | output | 1 | High while a frame is being sent |

## Verification
Two events can fall in the same clock edge: the end of the last stop bit and the host dropping `send`. The bench provokes this by lowering `send` just before the edge that closes the frame, then raising it again one cycle later. The behavioural model must then show the block idle at once and starting the next frame with no gap. The opposite case, with `send` still high at that edge, is judged by holding `send` high for many bit periods and checking that the line stays high and `busy` stays low.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  localparam int MAX_DATA = 8;
  localparam int MAX_STOP = 2;
  localparam int FRAME_W  = 1 + MAX_DATA + 1 + MAX_STOP;
  localparam int LEN_W    = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic load;   // capture inputs, put start bit on the line
    logic shift;  // end of one bit period, advance to next bit
  } txStrobes_t;

  function automatic int dataBits(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5;
      2'b01:   return 7;
      default: return MAX_DATA;
    endcase
  endfunction

endpackage

// File: rtl/async_tx_datapath.sv
module async_tx_datapath
  import async_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  txStrobes_t          strobes,
  input  logic [MAX_DATA-1:0] dataIn,
  input  logic [1:0]          dataLen,
  input  logic                parityEn,
  input  logic                parityOdd,
  input  logic                stopTwo,
  output logic                txLine,
  output logic                lastBit
);

  logic [FRAME_W-1:0] frameNext;
  logic [FRAME_W-1:0] shiftReg;
  logic [LEN_W-1:0]   lenNext;
  logic [LEN_W-1:0]   bitsLeft;
  logic               parityBit;
  int                 nBits;

  // Build the whole frame at accept time: start, data LSB first, parity, stops.
  always_comb begin
    nBits     = dataBits(dataLen);
    parityBit = parityOdd;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < nBits) parityBit = parityBit ^ dataIn[i];
    end
    frameNext    = '1;
    frameNext[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < nBits) frameNext[i+1] = dataIn[i];
    end
    for (int p = 1; p < FRAME_W; p++) begin
      if (parityEn && (p == nBits + 1)) frameNext[p] = parityBit;
    end
    lenNext = LEN_W'(1 + nBits + (parityEn ? 1 : 0) + (stopTwo ? 2 : 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '1;
      bitsLeft <= '0;
    end else if (strobes.load) begin
      shiftReg <= frameNext;
      bitsLeft <= lenNext;
    end else if (strobes.shift) begin
      shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
      bitsLeft <= bitsLeft - LEN_W'(1);
    end
  end

  assign txLine  = shiftReg[0];
  assign lastBit = (bitsLeft == LEN_W'(1));

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> !txLine)
    else $error("start bit not low after accept");

  // R5
  line_high_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.shift && lastBit) |=> txLine)
    else $error("line not high after final stop bit");

endmodule

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
#(
  parameter int DIV = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       send,
  input  logic       lastBit,
  output txStrobes_t strobes,
  output logic       busy
);

  localparam int CNT_W = (DIV < 2) ? 1 : $clog2(DIV);

  typedef enum logic [1:0] {IDLE, FRAME, RELEASE} txState_t;

  txState_t         state;
  logic [CNT_W-1:0] baudCnt;
  logic             tick;

  always_comb begin
    tick          = (state == FRAME) && (baudCnt == CNT_W'(DIV - 1));
    strobes.load  = (state == IDLE) && send;
    strobes.shift = tick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= IDLE;
      baudCnt <= '0;
    end else begin
      case (state)
        IDLE: begin
          baudCnt <= '0;
          if (send) state <= FRAME;
        end
        FRAME: begin
          if (tick) begin
            baudCnt <= '0;
            if (lastBit) state <= send ? RELEASE : IDLE;
          end else begin
            baudCnt <= baudCnt + CNT_W'(1);
          end
        end
        default: begin
          if (!send) state <= IDLE;
        end
      endcase
    end
  end

  assign busy = (state == FRAME);

  // R6
  busy_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == IDLE) && send) |=> busy)
    else $error("busy did not follow accepted send");

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == RELEASE) && send) |=> !busy)
    else $error("frame restarted while send still held");

endmodule

// File: rtl/async_tx_hs.sv
module async_tx_hs
  import async_tx_pkg::*;
#(
  parameter int CLK_HZ = 200_000_000,
  parameter int BAUD   = 19_200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] dataIn,
  input  logic [1:0] dataLen,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       stopTwo,
  input  logic       send,
  output logic       txLine,
  output logic       busy
);

  localparam int DIV = CLK_HZ / BAUD;

  txStrobes_t strobes;
  logic       lastBit;

  async_tx_ctrl #(.DIV(DIV)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .send    (send),
    .lastBit (lastBit),
    .strobes (strobes),
    .busy    (busy)
  );

  async_tx_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .dataIn    (dataIn),
    .dataLen   (dataLen),
    .parityEn  (parityEn),
    .parityOdd (parityOdd),
    .stopTwo   (stopTwo),
    .txLine    (txLine),
    .lastBit   (lastBit)
  );

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txLine)
    else $error("line low outside a frame");

endmodule

// File: tb/async_tx_hs_bench.sv
`timescale 1ns/1ps
module async_tx_hs_bench;

  localparam int CLK_HZ = 200_000_000;
  localparam int BAUD   = 50_000_000;
  localparam int DIV    = CLK_HZ / BAUD;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] dataIn = 8'h00;
  logic [1:0] dataLen = 2'b10;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       stopTwo = 1'b0;
  logic       send = 1'b0;
  logic       txLine;
  logic       busy;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  async_tx_hs #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_async_tx_hs (
    .clk(clk), .rst(rst), .dataIn(dataIn), .dataLen(dataLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .stopTwo(stopTwo),
    .send(send), .txLine(txLine), .busy(busy)
  );

  // Behavioural reference: one queue entry per clock cycle of line level.
  bit q[$];
  int mState = 0;  // 0 idle, 1 sending, 2 waiting for send low
  bit mTx = 1'b1;
  bit mBusy = 1'b0;

  function automatic void buildFrame();
    int  n;
    bit  bits[$];
    bit  par;
    n = (dataLen == 2'b00) ? 5 : (dataLen == 2'b01) ? 7 : 8;
    bits.push_back(1'b0);
    par = parityOdd;
    for (int i = 0; i < n; i++) begin
      bits.push_back(dataIn[i]);
      par = par ^ dataIn[i];
    end
    if (parityEn) bits.push_back(par);
    bits.push_back(1'b1);
    if (stopTwo) bits.push_back(1'b1);
    foreach (bits[k]) for (int c = 0; c < DIV; c++) q.push_back(bits[k]);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      q.delete();
      mState = 0;
    end else begin
      case (mState)
        0: if (send) begin buildFrame(); mState = 1; end
        1: begin
          void'(q.pop_front());
          if (q.size() == 0) mState = send ? 2 : 0;
        end
        default: if (!send) mState = 0;
      endcase
    end
    mBusy = (mState == 1);
    mTx   = (q.size() > 0) ? q[0] : 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d",
               req, what, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (!rst) begin
      check(txLine === mTx, curReq, "txLine", int'(txLine), int'(mTx));
      check(busy === mBusy, "R6", "busy", int'(busy), int'(mBusy));
    end
  end

  task automatic waitBusy(input bit level);
    int guard = 0;
    while (busy !== level && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic setCfg(input logic [7:0] d, input logic [1:0] len,
                        input bit pe, input bit po, input bit st);
    dataIn = d; dataLen = len; parityEn = pe; parityOdd = po; stopTwo = st;
  endtask

  // Full handshake: raise send, wait busy, wait done, hold, release.
  task automatic frame(input logic [7:0] d, input logic [1:0] len,
                       input bit pe, input bit po, input bit st, input int hold);
    @(negedge clk);
    setCfg(d, len, pe, po, st);
    send = 1'b1;
    @(negedge clk);
    check(busy === 1'b1, "R6", "busy after accept", int'(busy), 1);
    waitBusy(1'b0);
    repeat (hold) @(negedge clk);
    send = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    curReq = "R1";
    check(txLine === 1'b1, "R1", "txLine in reset", int'(txLine), 1);
    check(busy === 1'b0, "R1", "busy in reset", int'(busy), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(txLine === 1'b1, "R2", "idle line", int'(txLine), 1);

    curReq = "R3";  // 8 bits, no parity, one stop
    frame(8'hA5, 2'b10, 1'b0, 1'b0, 1'b0, 0);
    frame(8'h3C, 2'b11, 1'b0, 1'b0, 1'b0, 1);
    curReq = "R3";  // 5 bits, upper bits must not appear
    frame(8'hF6, 2'b00, 1'b0, 1'b0, 1'b0, 0);

    curReq = "R4";  // 7 bits with parity, bit 7 set but outside the count
    frame(8'hD7, 2'b01, 1'b1, 1'b0, 1'b0, 0);
    frame(8'hD7, 2'b01, 1'b1, 1'b1, 1'b0, 0);
    frame(8'h13, 2'b00, 1'b1, 1'b1, 1'b0, 0);

    curReq = "R5";  // two stop bits
    frame(8'h81, 2'b10, 1'b1, 1'b0, 1'b1, 0);
    frame(8'h00, 2'b00, 1'b0, 1'b0, 1'b1, 0);

    curReq = "R7";  // send held high long after the frame
    @(negedge clk);
    setCfg(8'h5A, 2'b10, 1'b0, 1'b0, 1'b0);
    send = 1'b1;
    waitBusy(1'b1);
    waitBusy(1'b0);
    for (int k = 0; k < 6 * DIV; k++) begin
      check(busy === 1'b0, "R7", "busy while send held", int'(busy), 0);
      check(txLine === 1'b1, "R7", "line while send held", int'(txLine), 1);
      @(negedge clk);
    end
    send = 1'b0;
    repeat (2) @(negedge clk);

    curReq = "R8";  // inputs change mid-frame
    @(negedge clk);
    setCfg(8'h96, 2'b10, 1'b1, 1'b0, 1'b0);
    send = 1'b1;
    repeat (2 * DIV + 1) @(negedge clk);
    setCfg(8'h0F, 2'b00, 1'b0, 1'b1, 1'b1);
    waitBusy(1'b0);
    send = 1'b0;
    repeat (2) @(negedge clk);

    curReq = "R6";  // send released early, mid-frame
    @(negedge clk);
    setCfg(8'h6B, 2'b01, 1'b0, 1'b0, 1'b1);
    send = 1'b1;
    repeat (DIV + 2) @(negedge clk);
    send = 1'b0;
    waitBusy(1'b0);
    repeat (2) @(negedge clk);

    curReq = "R9";  // send released on the very edge that ends the frame
    @(negedge clk);
    setCfg(8'hC3, 2'b10, 1'b1, 1'b1, 1'b0);
    send = 1'b1;
    begin
      int guard = 0;
      while (!(mState == 1 && q.size() == 1) && guard < 1000) begin
        @(negedge clk);
        guard++;
      end
    end
    send = 1'b0;
    @(negedge clk);
    check(busy === 1'b0, "R9", "busy at frame end", int'(busy), 0);
    setCfg(8'h2E, 2'b01, 1'b0, 1'b0, 1'b0);
    send = 1'b1;
    @(negedge clk);
    check(busy === 1'b1, "R9", "back-to-back busy", int'(busy), 1);
    check(txLine === 1'b0, "R9", "back-to-back start bit", int'(txLine), 0);
    waitBusy(1'b0);
    send = 1'b0;
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule